// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Channel

This block takes a byte stream from a serial receiver and stores it in memory, following a ring of descriptors that are linked by pointers. Each descriptor occupies three 32-bit words at byte offsets +0, +4 and +8. Word +0 is the address of the next descriptor. Word +4 is the start address of the data buffer. Word +8 receives the result: bits 15:0 hold the length and bits 23:16 hold the status byte. Software supplies the current-descriptor address, the end-descriptor address and a per-buffer byte limit, then turns the channel on.

The engine loads a descriptor and fills its buffer one byte at a time. It then writes back the length and the status and follows the link to the next descriptor. A frame longer than the byte limit continues into the next descriptor, and only the last fragment carries end-of-message. The engine never processes the descriptor whose address equals the end address. It parks there, sets end-of-transfer, and resumes as soon as software moves the end address on. Bytes that arrive while the engine is parked are consumed and thrown away, and the channel records a buffer overflow.

Event flags are cleared by writing 1 to them, and only when a write-enable bit is also set. A frame counter raises an overflow flag when it wraps. A software abort puts the channel back into its initial state.

Top module: `rxdma_chain_top`

## Requirements
- R1: For each descriptor the engine reads the link word at +0 and the buffer address at +4. It stores the received bytes at consecutive byte addresses from that buffer address, using a one-hot byte enable on `mem_be`.
- R2: On completion the engine writes the word at descriptor +8 as {8'h00, status, length}. Status bit 7 is end-of-message. Status bits 4:0 copy `in_err` of the last byte: bit 0 overrun, bit 1 short frame, bit 2 abort, bit 3 residual bits, bit 4 CRC. Bits 6:5 are zero.
- R3: When a buffer reaches `buf_len` bytes and the frame has not ended, that descriptor is closed with status 0x00. The frame continues in the linked descriptor. A frame whose last byte lands exactly on the limit is a single final fragment. `buf_len` = 0 means 65536.
- R4: When the current address equals the end address, the engine performs no memory access, does not touch that descriptor, and sets end-of-transfer (`dma_status` bit 1).
- R5: Writing a new end address lets a parked engine resume at the current descriptor.
- R6: While parked, the engine accepts and discards input bytes and writes nothing to memory. On the discarded frame's last byte it sets buffer-overflow (`dma_status` bit 3). This also applies to the tail of a frame that runs out of descriptors.
- R7: A control write sets the channel enable from `ctl_wdata[0]` (`dma_status` bit 0). While the enable is 0, `in_ready` is low and no buffer is written.
- R8: On a control write with `ctl_wdata[1]` = 1, a 1 in `ctl_wdata[2]`, `[3]`, `[4]` or `[5]` clears end-of-transfer, end-of-message, buffer-overflow or counter-overflow respectively. When `ctl_wdata[1]` = 0, the flags are not changed.
- R9: Every final fragment written back sets end-of-message (`dma_status` bit 2) and increments `frame_count`. A wrap of the counter sets counter-overflow (`dma_status` bit 4).
- R10: `eom_irq` is high exactly when end-of-message is set and `eom_irq_en` is high.
- R11: `sw_abort` clears the enable, all flags and `frame_count`, and returns the engine to idle with `in_ready` low.
- R12: After reset, `dma_status`, `frame_count`, `in_ready`, `mem_req` and `eom_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_abort | input | 1 | Return channel to initial state |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 6 | [0] enable, [1] flag write-enable, [5:2] flag clear mask |
| cda_wr | input | 1 | Load current-descriptor address |
| cda_wdata | input | AW | Current-descriptor address value |
| eda_wr | input | 1 | Load end-descriptor address |
| eda_wdata | input | AW | End-descriptor address value |
| buf_len | input | 16 | Bytes per buffer (0 = 65536) |
| eom_irq_en | input | 1 | End-of-message interrupt enable |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Byte ends the frame |
| in_err | input | 5 | Error tags of the frame, sampled with the last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte enables of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| dma_status | output | 5 | {counter-ovf, buffer-ovf, end-of-msg, end-of-xfer, enable} |
| cur_desc | output | AW | Current-descriptor address |
| frame_count | output | CW | Completed-frame counter |
| eom_irq | output | 1 | End-of-message interrupt |

## Verification
The bench builds the channel with a 12-bit address and a 3-bit frame counter, so the counter wraps within a short run and counter-overflow can be reached. It uses a ring of four descriptors and a buffer limit of eight bytes. With these values a random frame of up to 24 bytes spans one to three fragments, exact-limit frames occur, and the end pointer wraps around the ring many times. Frames that outrun the free descriptors show how the tail is dropped.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int LEN_W    = 16;
    localparam int OFS_BUF  = 4;
    localparam int OFS_STAT = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHK,
        S_RDBUF,
        S_GOTBUF,
        S_FILL,
        S_WB,
        S_HALT
    } seq_state_e;

    typedef struct packed {
        logic cof;
        logic bof;
        logic eom;
        logic eot;
    } dma_flags_t;

endpackage

// File: rtl/rxdma_flags.sv
module rxdma_flags
    import rxdma_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          ctl_wr,
    input  logic [5:0]    ctl_wdata,
    input  logic          ev_eot,
    input  logic          ev_eom,
    input  logic          ev_bof,
    output logic          de,
    output dma_flags_t    flags,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic          de;
        dma_flags_t    f;
        logic [CW-1:0] cnt;
    } flag_s;

    flag_s q, d;

    always_comb begin
        d = q;
        if (ctl_wr) begin
            d.de = ctl_wdata[0];
            if (ctl_wdata[1]) begin
                if (ctl_wdata[2]) d.f.eot = 1'b0;
                if (ctl_wdata[3]) d.f.eom = 1'b0;
                if (ctl_wdata[4]) d.f.bof = 1'b0;
                if (ctl_wdata[5]) d.f.cof = 1'b0;
            end
        end
        if (ev_eot) d.f.eot = 1'b1;
        if (ev_bof) d.f.bof = 1'b1;
        if (ev_eom) begin
            d.f.eom = 1'b1;
            d.cnt   = q.cnt + 1'b1;
            if (&q.cnt) d.f.cof = 1'b1;
        end
        if (abort) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign de    = q.de;
    assign flags = q.f;
    assign count = q.cnt;

    assert_eot_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_eot && !abort) |=> q.f.eot);
    assert_bof_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bof && !abort) |=> q.f.bof);
    assert_abort_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (q == '0));

endmodule

// File: rtl/rxdma_seq.sv
module rxdma_seq
    import rxdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             de,
    input  logic             cda_wr,
    input  logic [AW-1:0]    cda_wdata,
    input  logic             eda_wr,
    input  logic [AW-1:0]    eda_wdata,
    input  logic [LEN_W-1:0] buflen,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [4:0]       in_err,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             ev_eot,
    output logic             ev_eom,
    output logic             ev_bof,
    output logic [AW-1:0]    cur_desc
);

    typedef struct packed {
        seq_state_e       st;
        logic [AW-1:0]    cda;
        logic [AW-1:0]    eda;
        logic [AW-1:0]    chain;
        logic [AW-1:0]    bufp;
        logic [LEN_W-1:0] len;
        logic [7:0]       stat;
        logic             drop;
    } seq_s;

    seq_s q, d;
    logic [AW-1:0] waddr;

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        in_ready  = 1'b0;
        ev_eot    = 1'b0;
        ev_eom    = 1'b0;
        ev_bof    = 1'b0;
        waddr     = q.bufp + AW'(q.len);
        if (cda_wr) d.cda = cda_wdata;
        if (eda_wr) d.eda = eda_wdata;
        case (q.st)
            S_IDLE: if (de) d.st = S_CHK;
            S_CHK: begin
                if (!de) begin
                    d.st = S_IDLE;
                end else if (q.cda == q.eda) begin
                    d.st   = S_HALT;
                    ev_eot = 1'b1;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = q.cda;
                    mem_be   = 4'hF;
                    d.st     = S_RDBUF;
                end
            end
            S_RDBUF: begin
                d.chain  = mem_rdata[AW-1:0];
                mem_req  = 1'b1;
                mem_addr = q.cda + AW'(OFS_BUF);
                mem_be   = 4'hF;
                d.st     = S_GOTBUF;
            end
            S_GOTBUF: begin
                d.bufp = mem_rdata[AW-1:0];
                d.len  = '0;
                d.st   = S_FILL;
            end
            S_FILL: begin
                in_ready = de;
                if (de && in_valid) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = waddr;
                    mem_be    = 4'b0001 << waddr[1:0];
                    mem_wdata = {4{in_data}};
                    d.len     = q.len + 1'b1;
                    if (in_last) begin
                        d.stat = {3'b100, in_err};
                        d.st   = S_WB;
                    end else if (q.len + 1'b1 == buflen) begin
                        d.stat = 8'h00;
                        d.st   = S_WB;
                    end
                end
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cda + AW'(OFS_STAT);
                mem_be    = 4'hF;
                mem_wdata = {8'h00, q.stat, q.len};
                ev_eom    = q.stat[7];
                d.cda     = q.chain;
                d.st      = S_CHK;
            end
            S_HALT: begin
                if (de) begin
                    in_ready = (q.cda == q.eda) || q.drop;
                    if (in_ready && in_valid) begin
                        if (in_last) begin
                            ev_bof = 1'b1;
                            d.drop = 1'b0;
                        end else begin
                            d.drop = 1'b1;
                        end
                    end
                    if ((q.cda != q.eda) && !d.drop) d.st = S_CHK;
                end
            end
            default: d.st = S_IDLE;
        endcase
        if (abort) begin
            d.st   = S_IDLE;
            d.drop = 1'b0;
            d.len  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_desc = q.cda;

    assert_len_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_FILL && buflen != '0) |-> (q.len < buflen));
    assert_off_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_FILL && !de) |-> !mem_req);
    assert_halt_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_HALT) |-> !mem_req);

endmodule

// File: rtl/rxdma_chain_top.sv
module rxdma_chain_top
    import rxdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_abort,
    input  logic             ctl_wr,
    input  logic [5:0]       ctl_wdata,
    input  logic             cda_wr,
    input  logic [AW-1:0]    cda_wdata,
    input  logic             eda_wr,
    input  logic [AW-1:0]    eda_wdata,
    input  logic [LEN_W-1:0] buf_len,
    input  logic             eom_irq_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [4:0]       in_err,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic [4:0]       dma_status,
    output logic [AW-1:0]    cur_desc,
    output logic [CW-1:0]    frame_count,
    output logic             eom_irq
);

    logic       de;
    logic       ev_eot, ev_eom, ev_bof;
    dma_flags_t flags;

    rxdma_flags #(.CW(CW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (sw_abort),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ev_eot    (ev_eot),
        .ev_eom    (ev_eom),
        .ev_bof    (ev_bof),
        .de        (de),
        .flags     (flags),
        .count     (frame_count)
    );

    rxdma_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (sw_abort),
        .de        (de),
        .cda_wr    (cda_wr),
        .cda_wdata (cda_wdata),
        .eda_wr    (eda_wr),
        .eda_wdata (eda_wdata),
        .buflen    (buf_len),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_err    (in_err),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .ev_eot    (ev_eot),
        .ev_eom    (ev_eom),
        .ev_bof    (ev_bof),
        .cur_desc  (cur_desc)
    );

    assign dma_status = {flags.cof, flags.bof, flags.eom, flags.eot, de};
    assign eom_irq    = flags.eom & eom_irq_en;

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_eom && !sw_abort && eom_irq_en) |=> eom_irq);

endmodule

// File: tb/rxdma_chain_top_tb.sv
module rxdma_chain_top_tb;

    localparam int AW = 12;
    localparam int CW = 3;
    localparam int BL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_abort = 1'b0;
    logic ctl_wr = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic cda_wr = 1'b0;
    logic [AW-1:0] cda_wdata = '0;
    logic eda_wr = 1'b0;
    logic [AW-1:0] eda_wdata = '0;
    logic [15:0] buf_len = 16'(BL);
    logic eom_irq_en = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_data = '0;
    logic in_last = 1'b0;
    logic [4:0] in_err = '0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [4:0] dma_status;
    logic [AW-1:0] cur_desc;
    logic [CW-1:0] frame_count;
    logic eom_irq;

    int checks = 0;
    int errors = 0;
    int cur = 0;
    int frames_done = 0;
    logic [7:0] fb [0:31];
    logic [31:0] mem [0:1023];

    always #5 clk = ~clk;

    rxdma_chain_top #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_abort(sw_abort),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cda_wr(cda_wr), .cda_wdata(cda_wdata),
        .eda_wr(eda_wr), .eda_wdata(eda_wdata),
        .buf_len(buf_len), .eom_irq_en(eom_irq_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_err(in_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dma_status(dma_status), .cur_desc(cur_desc),
        .frame_count(frame_count), .eom_irq(eom_irq)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
    end

    function automatic logic [7:0] mbyte(input int a);
        logic [31:0] w;
        w = mem[a / 4];
        return w[8*(a % 4) +: 8];
    endfunction

    function automatic logic [31:0] exp_word(input bit fin, input logic [4:0] e, input int n);
        logic [7:0] s;
        s = fin ? {3'b100, e} : 8'h00;
        return {8'h00, s, 16'(n)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ctl(input logic [5:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic set_eda(input int idx);
        @(negedge clk); eda_wr = 1'b1; eda_wdata = AW'(idx * 16);
        @(negedge clk); eda_wr = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input logic l, input logic [4:0] e);
        @(negedge clk);
        in_valid = 1'b1; in_data = v; in_last = l; in_err = e;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [4:0] e);
        for (int i = 0; i < n; i++) begin
            fb[i] = 8'($urandom);
            send_byte(fb[i], i == n - 1, e);
        end
    endtask

    task automatic wait_desc(input int idx);
        int t;
        t = 0;
        while (cur_desc != AW'(idx * 16) && t < 200) begin
            @(negedge clk); t++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_frame(input int n, input logic [4:0] e);
        int need, tgt, d, fl;
        need = (n + BL - 1) / BL;
        tgt = (cur + need) % 4;
        set_eda(tgt);
        send_frame(n, e);
        wait_desc(tgt);
        for (int k = 0; k < need; k++) begin
            d = (cur + k) % 4;
            fl = (k == need - 1) ? n - BL * k : BL;
            chk("R2/R3 descriptor result word", mem[d*4+2], exp_word(k == need - 1, e, fl));
            for (int j = 0; j < fl; j++)
                chk("R1 buffer byte", 32'(mbyte(256 + d*64 + j)), 32'(fb[BL*k + j]));
        end
        cur = tgt;
        frames_done++;
        chk("R9 frame counter", 32'(frame_count), 32'(frames_done % 8));
        chk("R5 parked at new end", 32'(cur_desc), 32'(tgt * 16));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int fc, n;
        logic [4:0] e;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++) begin
            mem[i*4+0] = 32'(((i + 1) % 4) * 16);
            mem[i*4+1] = 32'(256 + i * 64);
            mem[i*4+2] = 32'hDEAD_BEEF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 status after reset", 32'(dma_status), 32'h0);
        chk("R12 count after reset", 32'(frame_count), 32'h0);
        chk("R12 ready after reset", 32'(in_ready), 32'h0);
        chk("R12 no mem req after reset", 32'(mem_req), 32'h0);
        chk("R12 irq after reset", 32'(eom_irq), 32'h0);

        @(negedge clk); cda_wr = 1'b1; cda_wdata = '0; eda_wr = 1'b1; eda_wdata = '0;
        @(negedge clk); cda_wr = 1'b0; eda_wr = 1'b0;
        ctl(6'b000001);
        repeat (4) @(negedge clk);
        chk("R4 end-of-transfer at end descriptor", 32'(dma_status), 32'b00011);
        chk("R4 end descriptor untouched", mem[2], 32'hDEAD_BEEF);

        run_frame(5, 5'b00000);
        chk("R10 irq masked", 32'(eom_irq), 32'h0);
        eom_irq_en = 1'b1;
        @(negedge clk);
        chk("R10 irq enabled", 32'(eom_irq), 32'h1);
        run_frame(12, 5'b10000);
        run_frame(8, 5'b00001);
        run_frame(24, 5'b01010);

        ctl(6'b111101);
        @(negedge clk);
        chk("R8 no clear without write-enable", 32'(dma_status), 32'b00111);
        ctl(6'b111111);
        @(negedge clk);
        chk("R8 flags cleared", 32'(dma_status), 32'b00001);
        chk("R10 irq drops with flag", 32'(eom_irq), 32'h0);

        mem[cur*4+2] = 32'hDEAD_BEEF;
        fc = 32'(frame_count);
        send_frame(3, 5'b00000);
        repeat (2) @(negedge clk);
        chk("R6 overflow flag on dropped frame", 32'(dma_status), 32'b01001);
        chk("R6 parked descriptor untouched", mem[cur*4+2], 32'hDEAD_BEEF);
        chk("R6 dropped frame not counted", 32'(frame_count), 32'(fc));

        ctl(6'b111111);
        set_eda((cur + 1) % 4);
        send_frame(12, 5'b00000);
        repeat (3) @(negedge clk);
        chk("R6 truncated first fragment", mem[cur*4+2], exp_word(1'b0, 5'b0, BL));
        chk("R6 tail dropped sets overflow", 32'(dma_status), 32'b01011);
        cur = (cur + 1) % 4;

        ctl(6'b000000);
        @(negedge clk); in_valid = 1'b1; in_data = 8'h55;
        repeat (3) @(negedge clk);
        chk("R7 not ready while disabled", 32'(in_ready), 32'h0);
        chk("R7 enable bit clear", 32'(dma_status[0]), 32'h0);
        in_valid = 1'b0;
        ctl(6'b000001);

        for (int r = 0; r < 10; r++) begin
            n = 1 + int'($urandom % 24);
            e = 5'($urandom);
            run_frame(n, e);
        end
        chk("R9 counter overflow flag", 32'(dma_status[4]), 32'h1);

        @(negedge clk); sw_abort = 1'b1;
        @(negedge clk); sw_abort = 1'b0;
        @(negedge clk);
        chk("R11 status after abort", 32'(dma_status), 32'h0);
        chk("R11 count after abort", 32'(frame_count), 32'h0);
        chk("R11 not ready after abort", 32'(in_ready), 32'h0);
        chk("R11 irq after abort", 32'(eom_irq), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule